// File: doc/BRIEF.md
# Banked Data-Memory Move Unit

This block carries out byte-move instructions against a 4096-byte data register file. It takes 16-bit instruction words one per cycle and decodes four operations: loading a 4-bit literal into the bank register, storing the working register into a file location, reading a file location into the working register or back into itself, and a two-word copy from one full 12-bit address to another. The register file and the working register are outside the block. The block drives the file's single read/write port and a write strobe for the working register.

Short instructions carry only an 8-bit offset, and an access bit selects how the 12-bit address is formed. With the bit set, the bank register supplies the upper nibble. With the bit clear, the bank register is ignored: offsets below 0x80 reach the bottom of memory, and offsets from 0x80 up reach the top region at 0xF80 to 0xFFF. The copy instruction holds its source byte between its two words. The block signals through `expect_second` that the next word must be the copy's second word. A wrong second word cancels the copy and pulses `copy_err`.

Top module: `dmem_move_unit`

## Requirements
- R1: After reset, `bank_sel` is 0, `expect_second` is 0, and no register-file write occurs while no word is offered.
- R2: A word with upper byte 0x01, offered when no copy is pending, loads bits [3:0] into `bank_sel` from the next cycle on (0x0102 selects bank 2).
- R3: A word whose bits [15:9] are 0110111 stores `wreg_in` into the file in the same cycle. Bit 8 is the access bit and bits [7:0] are the offset.
- R4: With the access bit 0, the address is 0x000+offset for offsets 0x00 to 0x7F and 0xF00+offset for offsets 0x80 to 0xFF, whatever `bank_sel` holds.
- R5: With the access bit 1, the address is {bank_sel, offset}. For example, bank 2 and word 0x6F70 write 0x270.
- R6: A word whose bits [15:10] are 010100 with bit 9 (destination) equal to 0 drives `w_we` with the addressed byte on `w_wdata`, and does not write the file.
- R7: The same read word with bit 9 equal to 1 writes the addressed byte back to the same address in one cycle, and does not assert `w_we`.
- R8: A word with bits [15:12] = 1100 reads the 12-bit source address in bits [11:0] and keeps the byte. It writes nothing, and `expect_second` is 1 from the next cycle.
- R9: While `expect_second` is 1, a word with bits [15:12] = 1111 writes the kept byte to the 12-bit address in bits [11:0], and `expect_second` returns to 0.
- R10: While `expect_second` is 1, any other word writes nothing, raises `copy_err` in that cycle and cancels the copy.
- R11: Words not offered (`instr_valid` low), unrecognised words, and a 1111 word with no copy pending change neither the file, the working register nor `bank_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | An instruction word is offered this cycle |
| instr_word | input | 16 | Instruction word |
| wreg_in | input | 8 | Current working-register value |
| rf_rdata | input | 8 | Combinational read data of the register file |
| rf_addr | output | 12 | Register-file address |
| rf_we | output | 1 | Register-file write strobe, taken at the clock edge |
| rf_wdata | output | 8 | Register-file write data |
| w_we | output | 1 | Working-register write strobe |
| w_wdata | output | 8 | Working-register write data |
| bank_sel | output | 4 | Current bank register |
| expect_second | output | 1 | The next word must be the second copy word |
| copy_err | output | 1 | Pulse: the copy's second word was malformed |

## Verification
The bound checker watches every cycle for the following: address formation in both access modes, the store data, the in-place rewrite for the read with bit 9 set, the bank register moving only on its load word, the rise and fall of `expect_second` around a copy, the error pulse, and the two write strobes never firing together. Only the bench scenarios can show that bytes actually land at the right addresses in a modelled file. They also show that the copied byte is the one read at the first word, and that ignored words leave memory and the working register untouched.

// File: rtl/dmu_pkg.sv
package dmu_pkg;
    localparam int BANK_W = 4;
    localparam int OFF_W  = 8;
    localparam int ADDR_W = BANK_W + OFF_W;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        OP_NONE, OP_BANK, OP_STORE, OP_READ, OP_COPY1, OP_COPY2
    } op_e;

    typedef struct packed {
        op_e               op;
        logic              acc;
        logic              dst;
        logic [OFF_W-1:0]  off;
        logic [ADDR_W-1:0] full;
        logic [BANK_W-1:0] lit;
    } dec_t;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic              pend;
        logic [DATA_W-1:0] hold;
    } st_t;
endpackage

// File: rtl/dmu_decode.sv
module dmu_decode
    import dmu_pkg::*;
(
    input  logic [15:0] word,
    output dec_t        dec
);
    always_comb begin
        dec.acc  = word[8];
        dec.dst  = word[9];
        dec.off  = word[OFF_W-1:0];
        dec.full = word[ADDR_W-1:0];
        dec.lit  = word[BANK_W-1:0];
        if (word[15:8] == 8'h01)             dec.op = OP_BANK;
        else if (word[15:9] == 7'b0110111)   dec.op = OP_STORE;
        else if (word[15:10] == 6'b010100)   dec.op = OP_READ;
        else if (word[15:12] == 4'b1100)     dec.op = OP_COPY1;
        else if (word[15:12] == 4'b1111)     dec.op = OP_COPY2;
        else                                 dec.op = OP_NONE;
    end
endmodule

// File: rtl/dmu_addr_gen.sv
module dmu_addr_gen #(
    parameter int BANK_W = 4,
    parameter int OFF_W  = 8,
    localparam int ADDR_W = BANK_W + OFF_W
) (
    input  logic              acc,
    input  logic [BANK_W-1:0] bank,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] addr
);
    logic [BANK_W-1:0] upper;
    always_comb begin
        if (acc) upper = bank;
        else     upper = {BANK_W{off[OFF_W-1]}};
        addr = {upper, off};
    end
endmodule

// File: rtl/dmem_move_unit.sv
module dmem_move_unit
    import dmu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [15:0]       instr_word,
    input  logic [7:0]        wreg_in,
    input  logic [7:0]        rf_rdata,
    output logic [11:0]       rf_addr,
    output logic              rf_we,
    output logic [7:0]        rf_wdata,
    output logic              w_we,
    output logic [7:0]        w_wdata,
    output logic [3:0]        bank_sel,
    output logic              expect_second,
    output logic              copy_err
);
    dec_t              dec;
    st_t               st_d, st_q;
    logic [ADDR_W-1:0] fa;

    dmu_decode u_dec (.word(instr_word), .dec(dec));

    dmu_addr_gen #(.BANK_W(BANK_W), .OFF_W(OFF_W)) u_agen (
        .acc(dec.acc), .bank(st_q.bank), .off(dec.off), .addr(fa)
    );

    always_comb begin
        st_d     = st_q;
        rf_addr  = '0;
        rf_we    = 1'b0;
        rf_wdata = wreg_in;
        w_we     = 1'b0;
        w_wdata  = rf_rdata;
        copy_err = 1'b0;
        if (instr_valid) begin
            if (st_q.pend) begin
                st_d.pend = 1'b0;
                if (dec.op == OP_COPY2) begin
                    rf_addr  = dec.full;
                    rf_we    = 1'b1;
                    rf_wdata = st_q.hold;
                end else begin
                    copy_err = 1'b1;
                end
            end else begin
                case (dec.op)
                    OP_BANK:  st_d.bank = dec.lit;
                    OP_STORE: begin
                        rf_addr  = fa;
                        rf_we    = 1'b1;
                        rf_wdata = wreg_in;
                    end
                    OP_READ: begin
                        rf_addr = fa;
                        if (dec.dst) begin
                            rf_we    = 1'b1;
                            rf_wdata = rf_rdata;
                        end else begin
                            w_we = 1'b1;
                        end
                    end
                    OP_COPY1: begin
                        rf_addr   = dec.full;
                        st_d.hold = rf_rdata;
                        st_d.pend = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bank_sel      = st_q.bank;
    assign expect_second = st_q.pend;
endmodule

// File: rtl/dmu_checker.sv
module dmu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        instr_valid,
    input logic [15:0] instr_word,
    input logic [7:0]  wreg_in,
    input logic [7:0]  rf_rdata,
    input logic [11:0] rf_addr,
    input logic        rf_we,
    input logic [7:0]  rf_wdata,
    input logic        w_we,
    input logic [3:0]  bank_sel,
    input logic        expect_second,
    input logic        copy_err
);
    logic idle_ok, is_bank, is_store, is_rd;
    assign idle_ok  = instr_valid && !expect_second;
    assign is_bank  = idle_ok && instr_word[15:8] == 8'h01;
    assign is_store = idle_ok && instr_word[15:9] == 7'b0110111;
    assign is_rd    = idle_ok && instr_word[15:10] == 6'b010100;

    a_r2_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
        is_bank |=> bank_sel == $past(instr_word[3:0]));
    a_r11_bank_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !is_bank |=> $stable(bank_sel));
    a_r3_store_data: assert property (@(posedge clk) disable iff (!rst_n)
        is_store |-> rf_we && rf_wdata == wreg_in);
    a_r4_access_map: assert property (@(posedge clk) disable iff (!rst_n)
        (is_store && !instr_word[8]) |->
        rf_addr == {{4{instr_word[7]}}, instr_word[7:0]});
    a_r5_banked_map: assert property (@(posedge clk) disable iff (!rst_n)
        (is_store && instr_word[8]) |-> rf_addr == {bank_sel, instr_word[7:0]});
    a_r6_single_dest: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_we && w_we));
    a_r7_rewrite: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && instr_word[9]) |-> rf_we && rf_wdata == rf_rdata && !w_we);
    a_r8_copy_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_ok && instr_word[15:12] == 4'hC) |=> expect_second);
    a_r9_copy_done: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && expect_second) |=> !expect_second);
    a_r10_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        copy_err |-> instr_valid && expect_second && !rf_we);
endmodule

bind dmem_move_unit dmu_checker u_chk (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .wreg_in(wreg_in), .rf_rdata(rf_rdata), .rf_addr(rf_addr), .rf_we(rf_we),
    .rf_wdata(rf_wdata), .w_we(w_we), .bank_sel(bank_sel),
    .expect_second(expect_second), .copy_err(copy_err)
);

// File: tb/sim_dmem_move_unit.sv
`timescale 1ns/1ps
module sim_dmem_move_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = '0;
    logic [7:0]  wreg = 8'h00;
    logic [7:0]  rf_rdata;
    logic [11:0] rf_addr;
    logic        rf_we, w_we, expect_second, copy_err;
    logic [7:0]  rf_wdata, w_wdata;
    logic [3:0]  bank_sel;
    logic [7:0]  mem [4096];
    int checks = 0, fails = 0;
    logic s_we, s_wwe, s_err;
    logic [11:0] s_addr;
    logic [7:0]  s_wdata, s_wwdata;

    always #5 clk = ~clk;

    dmem_move_unit u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .wreg_in(wreg), .rf_rdata(rf_rdata), .rf_addr(rf_addr), .rf_we(rf_we),
        .rf_wdata(rf_wdata), .w_we(w_we), .w_wdata(w_wdata), .bank_sel(bank_sel),
        .expect_second(expect_second), .copy_err(copy_err)
    );

    assign rf_rdata = mem[rf_addr];
    always @(posedge clk) begin
        if (rf_we) mem[rf_addr] <= rf_wdata;
        if (w_we)  wreg <= w_wdata;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic v, input logic [15:0] w);
        @(negedge clk);
        instr_valid = v;
        instr_word  = w;
        #2;
        s_we = rf_we; s_addr = rf_addr; s_wdata = rf_wdata;
        s_wwe = w_we; s_wwdata = w_wdata; s_err = copy_err;
        @(posedge clk);
        #1;
        instr_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 bank after reset", bank_sel, 0);
        chk("R1 pending after reset", expect_second, 0);
        send(1'b0, 16'h0000);
        chk("R1 no write idle", s_we, 0);
    endtask

    task automatic t_bank_store();
        send(1'b1, 16'h0102);
        chk("R2 bank load", bank_sel, 2);
        wreg = 8'h2A;
        send(1'b1, 16'h6F70);
        chk("R5 banked addr", s_addr, 12'h270);
        chk("R3 store strobe", s_we, 1);
        chk("R3 stored byte", mem[12'h270], 8'h2A);
        send(1'b1, 16'h6E70);
        chk("R4 access low addr", s_addr, 12'h070);
        send(1'b1, 16'h6E90);
        chk("R4 access high addr", s_addr, 12'hF90);
        chk("R4 high byte", mem[12'hF90], 8'h2A);
    endtask

    task automatic t_read();
        mem[12'h01D] = 8'h5C;
        wreg = 8'h00;
        send(1'b1, 16'h501D);
        chk("R6 w strobe", s_wwe, 1);
        chk("R6 no file write", s_we, 0);
        chk("R6 w value", wreg, 8'h5C);
        send(1'b1, 16'h521D);
        chk("R7 rewrite strobe", s_we, 1);
        chk("R7 rewrite addr", s_addr, 12'h01D);
        chk("R7 rewrite data", s_wdata, 8'h5C);
        chk("R7 no w strobe", s_wwe, 0);
        send(1'b1, 16'h010F);
        mem[12'hF10] = 8'hB4;
        send(1'b1, 16'h5110);
        chk("R5 banked read", wreg, 8'hB4);
    endtask

    task automatic t_copy();
        mem[12'h1A0] = 8'h77;
        mem[12'h23F] = 8'h00;
        send(1'b1, 16'hC1A0);
        chk("R8 no write first", s_we, 0);
        chk("R8 source addr", s_addr, 12'h1A0);
        chk("R8 pending", expect_second, 1);
        mem[12'h1A0] = 8'h12;
        send(1'b1, 16'hF23F);
        chk("R9 dest addr", s_addr, 12'h23F);
        chk("R9 held byte", mem[12'h23F], 8'h77);
        chk("R9 pending clear", expect_second, 0);
    endtask

    task automatic t_abort();
        mem[12'h040] = 8'h99;
        send(1'b1, 16'hC300);
        send(1'b1, 16'h6E40);
        chk("R10 error pulse", s_err, 1);
        chk("R10 no write", s_we, 0);
        chk("R10 memory kept", mem[12'h040], 8'h99);
        chk("R10 pending clear", expect_second, 0);
        send(1'b1, 16'h0000);
        chk("R10 error single", s_err, 0);
    endtask

    task automatic t_ignored();
        wreg = 8'h3C;
        send(1'b0, 16'h0105);
        chk("R11 idle bank kept", bank_sel, 4'hF);
        send(1'b0, 16'h6E41);
        chk("R11 idle no write", mem[12'h041], 8'h00);
        send(1'b1, 16'hF040);
        chk("R11 stray second no write", s_we, 0);
        chk("R11 stray second memory", mem[12'h040], 8'h99);
        send(1'b1, 16'h8888);
        chk("R11 unknown no w", s_wwe, 0);
        chk("R11 unknown w kept", wreg, 8'h3C);
        chk("R11 unknown bank kept", bank_sel, 4'hF);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        #23 rst_n = 1'b1;
        t_reset();
        t_bank_store();
        t_read();
        t_copy();
        t_abort();
        t_ignored();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule